// File: doc/BRIEF.md
# Trap Status and Cause Unit

This block sits beside a processor core and decides, cycle by cycle, whether execution must be diverted to the trap handler. It watches a bank of hardware interrupt request lines and three exception flags raised by the core: undefined instruction, arithmetic overflow and division by zero. Interrupts are qualified by a global enable bit and by a mask bit for each line. Exceptions are never masked. When either source fires, the unit raises a combinational take-trap output in the same cycle and presents a fixed handler address. Interrupts and exceptions share this single entry point.

On the clock edge where a trap is taken, the unit records three things. It latches the instruction address supplied by the core. It writes a 4-bit reason code into the cause register. It moves the global enable into a saved copy and then clears the enable, so that interrupts cannot nest. A return-from-trap pulse copies the saved enable back. Software reaches the status, cause and saved-address registers through a move-to/move-from coprocessor port. Reads are combinational from a register index, and writes take effect on the clock edge.

Top module: `trap_ctrl_unit`

## Requirements
- R1: After reset, status, cause and saved address all read 0, and the take-trap output is low.
- R2: While status bit 0 (global enable) is 0 and no exception input is high, the take-trap output stays low whatever the interrupt lines do.
- R3: Interrupt line n can raise the take-trap output only while status bit 8+n (its mask bit) is 1 and the global enable is 1.
- R4: Cause bits 15:8 show the raw interrupt lines in the same cycle, whatever the mask. Software writes to cause change only the code field in bits 5:2, and never bits 15:8.
- R5: A trap caused only by an interrupt writes code 0 into cause bits 5:2.
- R6: An exception raises the take-trap output even while the global enable is 0. It writes code 10 for undefined instruction, 12 for overflow and 9 for division by zero. When several are high together, the priority is undefined instruction, then overflow, then division by zero.
- R7: When an exception and an enabled interrupt arrive in the same cycle, the exception code is recorded.
- R8: On every trap, the saved-address register (index 14) captures the instruction address input of that cycle.
- R9: Trap entry copies status bit 0 into status bit 1 and clears bit 0. A return-from-trap pulse copies bit 1 back into bit 0 and leaves bit 1 unchanged.
- R10: Whenever the take-trap output is high, the handler address output equals the VECTOR parameter.
- R11: Writing 0x00001001 to status (index 12) enables interrupts with only line 4 unmasked. In that state, line 4 traps with code 0 and line 3 does not trap.
- R12: A trap taken in the same cycle as a software write to status discards that whole write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cp_wr_en_i | input | 1 | Coprocessor register write strobe |
| cp_addr_i | input | 5 | Register index for both read and write (12 status, 13 cause, 14 saved address) |
| cp_wdata_i | input | 32 | Write data |
| cp_rdata_o | output | 32 | Combinational read data for cp_addr_i |
| irq_i | input | 8 | Hardware interrupt request lines |
| exc_illegal_i | input | 1 | Undefined instruction detected |
| exc_ovf_i | input | 1 | Arithmetic overflow detected |
| exc_div0_i | input | 1 | Division by zero detected |
| inst_pc_i | input | 32 | Address of the instruction currently executing |
| eret_i | input | 1 | Return-from-trap pulse |
| trap_o | output | 1 | Take the trap this cycle |
| trap_vec_o | output | 32 | Handler entry address |
| epc_o | output | 32 | Saved trap address |

## Verification
The bench builds the unit with its default parameters: 32-bit registers, eight interrupt lines with the mask field starting at bit 8, and a handler address of 0x00000180. With these values, the 0x00001001 enable pattern unmasks exactly line 4, and the adjacent line 3 can serve as a masked control case. The bench drives every exception alone and in overlapping combinations so that the priority order is visible in the recorded code. It also drives an exception together with an enabled interrupt, and a status write together with a trap, to exercise both same-cycle collisions.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int NUM_EXC  = 3;
  localparam int CODE_W   = 4;
  localparam int CODE_LSB = 2;

  typedef enum logic [CODE_W-1:0] {
    CODE_IRQ     = 4'd0,
    CODE_DIV0    = 4'd9,
    CODE_ILLEGAL = 4'd10,
    CODE_OVF     = 4'd12
  } exc_code_e;

  // index 0 is the highest priority
  function automatic exc_code_e exc_code_of(input int idx);
    case (idx)
      0:       return CODE_ILLEGAL;
      1:       return CODE_OVF;
      default: return CODE_DIV0;
    endcase
  endfunction
endpackage

// File: rtl/trap_priority.sv
module trap_priority
  import trap_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic               ie_i,
  input  logic [NUM_IRQ-1:0] mask_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [NUM_EXC-1:0] exc_i,
  output logic               take_o,
  output logic               exc_any_o,
  output exc_code_e          code_o
);
  logic [NUM_IRQ-1:0] irq_live;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    assign irq_live[g] = irq_i[g] & mask_i[g];
  end

  assign exc_any_o = |exc_i;
  assign take_o    = exc_any_o | (ie_i & |irq_live);

  always_comb begin
    code_o = CODE_IRQ;
    for (int i = NUM_EXC - 1; i >= 0; i--) begin
      if (exc_i[i]) code_o = exc_code_of(i);
    end
  end
endmodule

// File: rtl/trap_status_reg.sv
module trap_status_reg #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               wr_ie_i,
  input  logic               wr_pie_i,
  input  logic [NUM_IRQ-1:0] wr_mask_i,
  input  logic               trap_i,
  input  logic               eret_i,
  output logic               ie_o,
  output logic               pie_o,
  output logic [NUM_IRQ-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_o   <= 1'b0;
      pie_o  <= 1'b0;
      mask_o <= '0;
    end else if (trap_i) begin
      pie_o <= ie_o;
      ie_o  <= 1'b0;
    end else if (eret_i) begin
      ie_o <= pie_o;
    end else if (wr_en_i) begin
      ie_o   <= wr_ie_i;
      pie_o  <= wr_pie_i;
      mask_o <= wr_mask_i;
    end
  end
endmodule

// File: rtl/trap_cause_reg.sv
module trap_cause_reg
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_code_en_i,
  input  logic [CODE_W-1:0] wr_code_i,
  input  logic              wr_epc_en_i,
  input  logic [XLEN-1:0]   wr_epc_i,
  input  logic              trap_i,
  input  exc_code_e         trap_code_i,
  input  logic [XLEN-1:0]   pc_i,
  output logic [CODE_W-1:0] code_o,
  output logic [XLEN-1:0]   epc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o <= '0;
      epc_o  <= '0;
    end else if (trap_i) begin
      code_o <= trap_code_i;
      epc_o  <= pc_i;
    end else begin
      if (wr_code_en_i) code_o <= wr_code_i;
      if (wr_epc_en_i)  epc_o  <= wr_epc_i;
    end
  end
endmodule

// File: rtl/trap_ctrl_unit.sv
module trap_ctrl_unit
  import trap_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              NUM_IRQ    = 8,
  parameter int              IDX_W      = 5,
  parameter int              MASK_LSB   = 8,
  parameter int              STATUS_IDX = 12,
  parameter int              CAUSE_IDX  = 13,
  parameter int              EPC_IDX    = 14,
  parameter logic [XLEN-1:0] VECTOR     = 32'h0000_0180
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cp_wr_en_i,
  input  logic [IDX_W-1:0]   cp_addr_i,
  input  logic [XLEN-1:0]    cp_wdata_i,
  output logic [XLEN-1:0]    cp_rdata_o,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               exc_illegal_i,
  input  logic               exc_ovf_i,
  input  logic               exc_div0_i,
  input  logic [XLEN-1:0]    inst_pc_i,
  input  logic               eret_i,
  output logic               trap_o,
  output logic [XLEN-1:0]    trap_vec_o,
  output logic [XLEN-1:0]    epc_o
);
  logic               status_ie, status_pie, exc_any;
  logic [NUM_IRQ-1:0] status_mask;
  logic [CODE_W-1:0]  cause_code;
  exc_code_e          trap_code;
  logic               wr_status, wr_cause, wr_epc;
  logic [XLEN-1:0]    status_rd, cause_rd;

  assign wr_status = cp_wr_en_i && (cp_addr_i == IDX_W'(STATUS_IDX));
  assign wr_cause  = cp_wr_en_i && (cp_addr_i == IDX_W'(CAUSE_IDX));
  assign wr_epc    = cp_wr_en_i && (cp_addr_i == IDX_W'(EPC_IDX));

  trap_priority #(.NUM_IRQ(NUM_IRQ)) i_prio (
    .ie_i      (status_ie),
    .mask_i    (status_mask),
    .irq_i     (irq_i),
    .exc_i     ({exc_div0_i, exc_ovf_i, exc_illegal_i}),
    .take_o    (trap_o),
    .exc_any_o (exc_any),
    .code_o    (trap_code)
  );

  trap_status_reg #(.NUM_IRQ(NUM_IRQ)) i_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_status),
    .wr_ie_i   (cp_wdata_i[0]),
    .wr_pie_i  (cp_wdata_i[1]),
    .wr_mask_i (cp_wdata_i[MASK_LSB +: NUM_IRQ]),
    .trap_i    (trap_o),
    .eret_i    (eret_i),
    .ie_o      (status_ie),
    .pie_o     (status_pie),
    .mask_o    (status_mask)
  );

  trap_cause_reg #(.XLEN(XLEN)) i_cause (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_code_en_i (wr_cause),
    .wr_code_i    (cp_wdata_i[CODE_LSB +: CODE_W]),
    .wr_epc_en_i  (wr_epc),
    .wr_epc_i     (cp_wdata_i),
    .trap_i       (trap_o),
    .trap_code_i  (trap_code),
    .pc_i         (inst_pc_i),
    .code_o       (cause_code),
    .epc_o        (epc_o)
  );

  always_comb begin
    status_rd                        = '0;
    status_rd[0]                     = status_ie;
    status_rd[1]                     = status_pie;
    status_rd[MASK_LSB +: NUM_IRQ]   = status_mask;
    cause_rd                         = '0;
    cause_rd[CODE_LSB +: CODE_W]     = cause_code;
    cause_rd[MASK_LSB +: NUM_IRQ]    = irq_i;
  end

  always_comb begin
    if (cp_addr_i == IDX_W'(STATUS_IDX))     cp_rdata_o = status_rd;
    else if (cp_addr_i == IDX_W'(CAUSE_IDX)) cp_rdata_o = cause_rd;
    else if (cp_addr_i == IDX_W'(EPC_IDX))   cp_rdata_o = epc_o;
    else                                     cp_rdata_o = '0;
  end

  assign trap_vec_o = VECTOR;
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk #(
  parameter int              XLEN   = 32,
  parameter int              CODE_W = 4,
  parameter logic [XLEN-1:0] VECTOR = 32'h0000_0180
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trap_o,
  input logic [XLEN-1:0]   trap_vec_o,
  input logic [XLEN-1:0]   inst_pc_i,
  input logic [XLEN-1:0]   epc_o,
  input logic              eret_i,
  input logic              exc_any,
  input logic              status_ie,
  input logic              status_pie,
  input logic [CODE_W-1:0] cause_code
);
  AST_NO_TRAP_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_ie && !exc_any) |-> !trap_o); // R2
  AST_IRQ_CODE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && !exc_any) |=> cause_code == '0); // R5
  AST_EXC_CODE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && exc_any) |=> cause_code != '0); // R6
  AST_EPC_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> epc_o == $past(inst_pc_i)); // R8
  AST_IE_SAVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> (!status_ie && status_pie == $past(status_ie))); // R9
  AST_ERET_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eret_i && !trap_o) |=> status_ie == $past(status_pie)); // R9
  AST_VECTOR_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> trap_vec_o == VECTOR); // R10
endmodule

bind trap_ctrl_unit trap_ctrl_chk #(
  .XLEN   (XLEN),
  .CODE_W (trap_pkg::CODE_W),
  .VECTOR (VECTOR)
) i_trap_ctrl_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .trap_o     (trap_o),
  .trap_vec_o (trap_vec_o),
  .inst_pc_i  (inst_pc_i),
  .epc_o      (epc_o),
  .eret_i     (eret_i),
  .exc_any    (exc_any),
  .status_ie  (status_ie),
  .status_pie (status_pie),
  .cause_code (cause_code)
);

// File: tb/test_trap_ctrl_unit.sv
module test_trap_ctrl_unit;
  localparam logic [4:0]  ST = 5'd12, CA = 5'd13, EP = 5'd14;
  localparam logic [31:0] VEC = 32'h0000_0180;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cp_wr_en = 1'b0;
  logic [4:0]  cp_addr = '0;
  logic [31:0] cp_wdata = '0, cp_rdata;
  logic [7:0]  irq = '0;
  logic        exc_ill = 1'b0, exc_ovf = 1'b0, exc_div = 1'b0, eret = 1'b0;
  logic [31:0] pc = '0, trap_vec, epc;
  logic        trap;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  trap_ctrl_unit i_trap_ctrl_unit (
    .clk_i(clk), .rst_ni(rst_n), .cp_wr_en_i(cp_wr_en), .cp_addr_i(cp_addr),
    .cp_wdata_i(cp_wdata), .cp_rdata_o(cp_rdata), .irq_i(irq),
    .exc_illegal_i(exc_ill), .exc_ovf_i(exc_ovf), .exc_div0_i(exc_div),
    .inst_pc_i(pc), .eret_i(eret), .trap_o(trap), .trap_vec_o(trap_vec), .epc_o(epc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] idx, output logic [31:0] v);
    cp_addr = idx;
    #1;
    v = cp_rdata;
  endtask

  task automatic wr(input logic [4:0] idx, input logic [31:0] d);
    cp_wr_en = 1'b1; cp_addr = idx; cp_wdata = d;
    tick();
    cp_wr_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(ST, v); check("R1 status", v, 32'h0);
    rd(CA, v); check("R1 cause", v, 32'h0);
    rd(EP, v); check("R1 epc", v, 32'h0);
    check("R1 trap", {31'b0, trap}, 32'h0);
  endtask

  task automatic t_global_off();
    logic [31:0] v;
    wr(ST, 32'h0000_FF00);
    irq = 8'hFF; #1;
    check("R2 trap with enable low", {31'b0, trap}, 32'h0);
    rd(CA, v); check("R4 mirror unmasked", v, 32'h0000_FF00);
    irq = 8'h00;
  endtask

  task automatic t_line4();
    logic [31:0] v;
    wr(ST, 32'h0000_1001);
    pc = 32'h0000_0400;
    irq = 8'h08; #1;
    check("R3 line3 masked", {31'b0, trap}, 32'h0);
    irq = 8'h10; #1;
    check("R11 line4 traps", {31'b0, trap}, 32'h1);
    check("R10 vector", trap_vec, VEC);
    tick();
    rd(CA, v); check("R5 code zero", v, 32'h0000_1000);
    rd(EP, v); check("R8 epc", v, 32'h0000_0400);
    rd(ST, v); check("R9 enable saved and cleared", v, 32'h0000_1002);
    check("R9 no nesting", {31'b0, trap}, 32'h0);
    eret = 1'b1; tick(); eret = 1'b0;
    rd(ST, v); check("R9 eret restores", v, 32'h0000_1003);
    check("R9 irq retakes", {31'b0, trap}, 32'h1);
    irq = 8'h00;
  endtask

  task automatic t_cause_write();
    logic [31:0] v;
    wr(ST, 32'h0);
    wr(CA, 32'hFFFF_FFFF);
    irq = 8'hA5;
    rd(CA, v); check("R4 only code writable", v, 32'h0000_A53C);
    irq = 8'h00;
  endtask

  task automatic t_exc(input logic i, input logic o, input logic d,
                       input logic [31:0] pcv, input logic [31:0] exp_cause);
    logic [31:0] v;
    pc = pcv; exc_ill = i; exc_ovf = o; exc_div = d; #1;
    check("R6 exception traps with enable low", {31'b0, trap}, 32'h1);
    tick();
    exc_ill = 1'b0; exc_ovf = 1'b0; exc_div = 1'b0;
    rd(CA, v); check("R6 code", v, exp_cause);
    rd(EP, v); check("R8 epc exc", v, pcv);
  endtask

  task automatic t_exc_vs_irq();
    logic [31:0] v;
    wr(ST, 32'h0000_1001);
    irq = 8'h10; exc_div = 1'b1; pc = 32'h0000_0900;
    tick();
    exc_div = 1'b0;
    rd(CA, v); check("R7 exception wins", v, 32'h0000_1024);
    irq = 8'h00;
  endtask

  task automatic t_write_vs_trap();
    logic [31:0] v;
    wr(ST, 32'h0000_1001);
    irq = 8'h10;
    wr(ST, 32'h0000_FF01);
    irq = 8'h00;
    rd(ST, v); check("R12 write discarded", v, 32'h0000_1002);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #2;
    t_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_global_off();
    t_line4();
    t_cause_write();
    t_exc(1'b0, 1'b1, 1'b0, 32'h0000_0500, 32'h0000_0030);
    t_exc(1'b1, 1'b0, 1'b0, 32'h0000_0504, 32'h0000_0028);
    t_exc(1'b0, 1'b0, 1'b1, 32'h0000_0508, 32'h0000_0024);
    t_exc(1'b1, 1'b1, 1'b1, 32'h0000_050C, 32'h0000_0028);
    t_exc(1'b0, 1'b1, 1'b1, 32'h0000_0510, 32'h0000_0030);
    t_exc_vs_irq();
    t_write_vs_trap();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule